// File: doc/BRIEF.md
# Hard-Decision Viterbi Decoder for a 64-State Rate-1/2 Code

This block takes a frame of received code-bit pairs from a rate-1/2 convolutional code with constraint length 7 and returns the most likely message bits. It handles one pair per accepted cycle. For each of the 64 trellis states it computes Hamming branch metrics, then runs an add-compare-select step. It writes one survivor decision bit per state for each stage into a frame-deep memory.

When the frame closes, the decoder scans all 64 path metrics for the smallest one. It traces back from that state through the stored decisions and places each recovered bit at its own stage index in an output buffer. It then streams the bits out oldest first, one per cycle, each with a valid strobe. While it is searching, tracing back or streaming, the decoder reports busy and ignores any input.

Top module: `vit_hd_dec`

## Requirements
- R1: The code register is {d(n), d(n-1), ..., d(n-6)}. The expected pair is in_sym[1] = d(n)^d(n-1)^d(n-2)^d(n-3) and in_sym[0] = d(n)^d(n-2)^d(n-3)^d(n-5). A frame received without error decodes back to its exact message.
- R2: The branch metric is the Hamming distance between in_sym and each branch's expected pair. A frame whose last six message bits are zero decodes correctly with any single received bit inverted.
- R3: In the compare step, a tie keeps the path from the lower-numbered predecessor. In the final search, a tie picks the lowest-numbered state. For a one-stage frame, the pairs 2'b10 and 2'b01 therefore decode to 0, and 2'b11 decodes to 1.
- R4: Every frame starts with state 0 at metric 0 and every other state at a large metric. A frame decodes correctly whatever frame came before it.
- R5: A frame of N accepted pairs yields exactly N out_valid strobes on consecutive cycles. The bits come out in message order, and out_last is high only with the N-th strobe.
- R6: busy rises in the cycle after the frame closes. It stays high until the cycle after the last output. While busy is high, in_valid, in_sym and in_last have no effect.
- R7: A frame closes when a pair arrives with in_last high, or when the MAXD-th pair is accepted.
- R8: After reset, busy, out_valid and out_last are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_sym holds a received pair this cycle |
| in_sym | input | 2 | Received pair, bit 1 from the first generator |
| in_last | input | 1 | This pair is the final stage of the frame |
| busy | output | 1 | Decoder is searching, tracing back or emitting |
| out_valid | output | 1 | out_bit holds a decoded bit |
| out_bit | output | 1 | Decoded message bit |
| out_last | output | 1 | Marks the final decoded bit of the frame |

## Verification
The assertions assume three things about the inputs: a frame never holds more pairs than MAXD, in_valid is low during reset, and in_sym is a defined value whenever in_valid is high. The stimulus changes inputs only on falling clock edges. It builds every frame from a bench-side encoder, and it keeps frames at or below 128 stages. Pairs driven while the decoder is busy are deliberate junk, meant to show they are ignored. Frames used for error correction end in six zero bits, so the correct path finishes at state 0.

// File: rtl/vit_hd_dec.sv
module vit_hd_dec #(
  parameter int MAXD = 128,
  parameter logic [6:0] G0 = 7'h78,
  parameter logic [6:0] G1 = 7'h5A,
  parameter int MW = 8,
  parameter int INITPM = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] in_sym,
  input  logic       in_last,
  output logic       busy,
  output logic       out_valid,
  output logic       out_bit,
  output logic       out_last
);
  localparam int SW = 6;
  localparam int NS = 1 << SW;
  localparam int AW = $clog2(MAXD);
  localparam int CW = $clog2(MAXD + 1);

  typedef enum logic [1:0] {RX, MIN, TB, OUT} ph_t;
  ph_t ph;

  logic [MW-1:0] pm [NS];
  logic [MW-1:0] pm_nx [NS];
  logic [NS-1:0] dec_nx;
  logic [NS-1:0] dmem [MAXD];
  logic [MAXD-1:0] obuf;
  logic [CW-1:0] len, ptr;
  logic [SW:0] sidx;
  logic [SW-1:0] best;
  logic [MW-1:0] bestm;

  function automatic logic [1:0] bmet(input logic [6:0] r, input logic [1:0] s);
    logic a, b;
    a = ^(r & G0) ^ s[1];
    b = ^(r & G1) ^ s[0];
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [MW-1:0] sadd(input logic [MW-1:0] a, input logic [1:0] b);
    logic [MW:0] t;
    t = {1'b0, a} + {{(MW-1){1'b0}}, b};
    return t[MW] ? '1 : t[MW-1:0];
  endfunction

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      logic [SW-1:0] s;
      logic [MW-1:0] c0, c1;
      s = SW'(i);
      c0 = sadd(pm[{s[SW-2:0], 1'b0}], bmet({s, 1'b0}, in_sym));
      c1 = sadd(pm[{s[SW-2:0], 1'b1}], bmet({s, 1'b1}, in_sym));
      dec_nx[i] = c1 < c0;
      pm_nx[i] = (c1 < c0) ? c1 : c0;
    end
  end

  assign busy      = ph != RX;
  assign out_valid = ph == OUT;
  assign out_bit   = obuf[AW'(ptr)];
  assign out_last  = (ph == OUT) && (ptr == len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || (ph == OUT && ptr == len - 1'b1)) begin
      ph <= RX;
      len <= '0;
      ptr <= '0;
      sidx <= '0;
      best <= '0;
      bestm <= '1;
      for (int i = 0; i < NS; i++) pm[i] <= (i == 0) ? '0 : MW'(INITPM);
    end else begin
      case (ph)
        RX: if (in_valid) begin
          for (int i = 0; i < NS; i++) pm[i] <= pm_nx[i];
          len <= len + 1'b1;
          if (in_last || len == CW'(MAXD - 1)) begin
            ph <= MIN;
            sidx <= '0;
            bestm <= '1;
            best <= '0;
          end
        end
        MIN: begin
          if (pm[sidx[SW-1:0]] < bestm) begin
            bestm <= pm[sidx[SW-1:0]];
            best <= sidx[SW-1:0];
          end
          sidx <= sidx + 1'b1;
          if (sidx == (SW+1)'(NS - 1)) begin
            ph <= TB;
            ptr <= len;
          end
        end
        TB: begin
          best <= {best[SW-2:0], dmem[AW'(ptr - 1'b1)][best]};
          ptr <= ptr - 1'b1;
          if (ptr == CW'(1)) ph <= OUT;
        end
        OUT: ptr <= ptr + 1'b1;
        default: ph <= RX;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ph == RX && in_valid) dmem[AW'(len)] <= dec_nx;
    if (ph == TB) obuf[AW'(ptr - 1'b1)] <= best[SW-1];
  end
endmodule

// File: rtl/vit_hd_dec_chk.sv
module vit_hd_dec_chk #(
  parameter int MW = 8,
  parameter int INITPM = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_last,
  input logic          busy,
  input logic          out_valid,
  input logic          out_last,
  input logic [MW-1:0] pm_zero,
  input logic [MW-1:0] pm_one
);
  p_close_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && in_last) |=> busy);

  p_busy_ends_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_last));

  p_single_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  p_out_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  p_busy_from_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid));

  p_frame_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (pm_zero == '0 && pm_one == MW'(INITPM)));
endmodule

bind vit_hd_dec vit_hd_dec_chk #(.MW(MW), .INITPM(INITPM)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .busy(busy), .out_valid(out_valid), .out_last(out_last),
  .pm_zero(pm[0]), .pm_one(pm[1])
);

// File: tb/vit_hd_dec_tb_top.sv
module vit_hd_dec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_sym = 2'b00;
  logic in_last = 1'b0;
  logic busy, out_valid, out_bit, out_last;

  int tests = 0, fails = 0, cyc = 0;
  logic msg [256];
  logic rx [256];
  int rxn;
  bit last_ok;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  vit_hd_dec dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
    .in_last(in_last), .busy(busy), .out_valid(out_valid), .out_bit(out_bit),
    .out_last(out_last));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic make_msg(input int n, input bit tail);
    for (int i = 0; i < n; i++) msg[i] = rnd();
    if (tail) for (int i = n - 6; i < n; i++) msg[i] = 1'b0;
  endtask

  task automatic send(input int n, input int e, input bit use_last);
    logic [5:0] h = 6'd0;
    for (int i = 0; i < n; i++) begin
      logic c1, c2, b;
      b = msg[i];
      c1 = b ^ h[5] ^ h[4] ^ h[3];
      c2 = b ^ h[4] ^ h[3] ^ h[1];
      if (e == 2 * i) c1 = ~c1;
      if (e == 2 * i + 1) c2 = ~c2;
      @(negedge clk);
      in_valid = 1'b1; in_sym = {c1, c2}; in_last = use_last && (i == n - 1);
      h = {b, h[5:1]};
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic collect(input int n);
    int t = 0;
    rxn = 0; last_ok = 1'b1;
    while (!out_valid && t < 1000) begin @(negedge clk); t++; end
    while (out_valid && rxn < 256) begin
      rx[rxn] = out_bit;
      if (out_last != (rxn == n - 1)) last_ok = 1'b0;
      rxn++;
      @(negedge clk);
    end
  endtask

  task automatic compare(input int n, input string req);
    int bad = -1;
    for (int i = 0; i < n; i++) if (bad < 0 && rx[i] !== msg[i]) bad = i;
    check(rxn == n, {req, " count"}, rxn, n);
    check(bad < 0, {req, " bits (first bad index)"}, bad, -1);
  endtask

  task automatic t_reset();
    check(busy == 1'b0 && out_valid == 1'b0 && out_last == 1'b0, "R8 reset outputs",
          {busy, out_valid, out_last}, 0);
  endtask

  task automatic t_clean();
    make_msg(40, 1'b1); send(40, -1, 1'b1); collect(40);
    compare(40, "R1 clean frame");
    check(last_ok, "R5 out_last position", last_ok, 1);
    make_msg(17, 1'b0); send(17, -1, 1'b1); collect(17);
    compare(17, "R5 order no tail");
  endtask

  task automatic t_single_err();
    int pos [5] = '{0, 1, 37, 60, 79};
    foreach (pos[k]) begin
      make_msg(40, 1'b1); send(40, pos[k], 1'b1); collect(40);
      compare(40, "R2 single error");
    end
  endtask

  task automatic t_tie();
    logic [1:0] s [3] = '{2'b10, 2'b01, 2'b11};
    logic e [3] = '{1'b0, 1'b0, 1'b1};
    foreach (s[k]) begin
      @(negedge clk); in_valid = 1'b1; in_sym = s[k]; in_last = 1'b1;
      @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
      collect(1);
      check(rxn == 1 && rx[0] === e[k], "R3 tie break", rx[0], e[k]);
    end
  endtask

  task automatic t_back2back();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); in_valid = 1'b1; in_sym = {rnd(), rnd()}; in_last = (i == 59);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    collect(60);
    check(rxn == 60, "R4 junk frame count", rxn, 60);
    make_msg(30, 1'b1); send(30, 11, 1'b1); collect(30);
    compare(30, "R4 frame after junk");
  endtask

  task automatic t_ignore();
    make_msg(25, 1'b1); send(25, -1, 1'b1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); in_valid = 1'b1; in_sym = {rnd(), rnd()}; in_last = 1'b1;
    end
    check(busy == 1'b1, "R6 busy held", busy, 1);
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    collect(25);
    compare(25, "R6 input ignored");
    @(negedge clk);
    check(busy == 1'b0, "R6 busy released", busy, 0);
    make_msg(20, 1'b1); send(20, -1, 1'b1); collect(20);
    compare(20, "R6 next frame clean");
  endtask

  task automatic t_cap();
    make_msg(128, 1'b1); send(128, 200, 1'b0);
    @(negedge clk);
    check(busy == 1'b1, "R7 cap closes frame", busy, 1);
    collect(128);
    compare(128, "R7 full-depth frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_clean();
    t_single_err();
    t_tie();
    t_back2back();
    t_ignore();
    t_cap();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule